// File: doc/BRIEF.md
# Byte-Addressed 16-bit Timer with Software Compare Channel

This block is a 16-bit up-counter reached through a small 8-bit register bus. A control register picks the counting source and a power-of-two prescale. A single compare channel holds a 16-bit match value and sets a channel flag when the counter reaches it. An enable bit routes that flag to an interrupt request line. No pin is driven on a match: the channel only signals software.

Software reaches every 16-bit quantity one byte at a time, so the block keeps each wide value coherent. A counter snapshot is taken when the high byte is read. A new compare value is staged in holding bytes and used only once both halves have arrived. The channel flag can only be cleared by a two-step handshake, so a clear cannot be lost or issued by accident.

Register offsets on `bus_addr` are: 0 control, 1 counter high, 2 counter low, 3 channel status, 4 compare high, 5 compare low. Any other offset reads as zero.

Top module: `ocmp_timer`

## Requirements
- R1: Control bits [4:3] select the count source. 00 stops the counter. 01 counts on every clock. 10 and 11 count on each clock in which `alt_tick` is high.
- R2: Control bits [2:0] hold a prescale code p. The counter advances once for every 2^p cycles of the selected source, so 000 divides by 1 and 111 divides by 128. The divider restarts from zero whenever the counter is written.
- R3: A write of any data to offset 1 or offset 2 sets the whole counter to 0x0000 on the next clock. The counter wraps from 0xFFFF to 0x0000.
- R4: The channel flag (status bit 7) sets on the prescaled tick at which the counter becomes equal to the committed compare value, and not before that tick.
- R5: `irq` is high exactly while the flag is set and the interrupt enable (status bit 6, written through offset 3) is 1.
- R6: A write to offset 3 with bit 7 = 0 clears the flag only if an earlier read of offset 3 returned the flag as 1. Writing bit 7 = 1 leaves the flag unchanged. A match in the same cycle as a clearing write leaves the flag set.
- R7: Compare value writes go to holding bytes. The committed 16-bit value, which is what offsets 4 and 5 read back, changes only when both bytes have been written since the last commit, in either order.
- R8: Reading offset 1 returns the counter high byte and captures the low byte. The next read of offset 2 returns the captured byte and releases the capture. A read of offset 2 with no capture pending returns the live low byte.
- R9: After reset, every register reads 0x00 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one byte per clock |
| bus_rd | input | 1 | Read strobe; its side effects take place at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| alt_tick | input | 1 | Alternate count-source enable |
| irq | output | 1 | Channel interrupt request |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 16-bit counter and a 3-bit prescale code. With the alternate source driven one pulse at a time, every counter value and compare match can be placed on an exact cycle. This includes a match that lands in the same cycle as a clearing write. The bus-clock source, at prescale codes 0, 3 and 7, checks the divide ratios against cycle counts worked out by hand. A run of 65,537 ticks carries the counter across its wrap point.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_CH_SC  = 3'd3;
  localparam logic [ADDR_W-1:0] A_VAL_HI = 3'd4;
  localparam logic [ADDR_W-1:0] A_VAL_LO = 3'd5;
  localparam int FLAG_BIT = 7;
  localparam int IE_BIT   = 6;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'b00,
    SRC_BUS  = 2'b01,
    SRC_ALT0 = 2'b10,
    SRC_ALT1 = 2'b11
  } src_sel_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      src_sel,
  input  logic [PS_W-1:0] ps_code,
  input  logic            alt_tick,
  input  logic            restart,
  output logic            tick
);
  localparam int DIV_W = (1 << PS_W) - 1;

  // Low-order ones mask: a tick is produced when the masked divider bits are all ones.
  function automatic logic [DIV_W-1:0] div_mask(input logic [PS_W-1:0] code);
    logic [DIV_W:0] one;
    one = 1;
    return DIV_W'((one << code) - 1'b1);
  endfunction

  logic [DIV_W-1:0] div_q;
  logic             src_en;
  logic [DIV_W-1:0] mask;

  always_comb begin
    src_en = (src_sel == tmr_pkg::SRC_BUS) | (src_sel[1] & alt_tick);
    mask   = div_mask(ps_code);
    tick   = src_en && ((div_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (restart) div_q <= '0;
    else if (src_en)  div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              clr,
  input  logic              rd_hi,
  input  logic              rd_lo,
  output logic [CNT_W-1:0]  count,
  output logic [BYTE_W-1:0] hi_byte,
  output logic [BYTE_W-1:0] lo_byte
);
  logic [BYTE_W-1:0] snap_q;
  logic              snap_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (tick) count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      snap_v <= 1'b0;
    end else if (clr) begin
      snap_v <= 1'b0;
    end else if (rd_hi) begin
      snap_q <= count[BYTE_W-1:0];
      snap_v <= 1'b1;
    end else if (rd_lo) begin
      snap_v <= 1'b0;
    end
  end

  always_comb begin
    hi_byte = count[CNT_W-1:BYTE_W];
    lo_byte = snap_v ? snap_q : count[BYTE_W-1:0];
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cnt_clr,
  input  logic [CNT_W-1:0]  count,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic              sc_rd,
  input  logic              sc_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  cmp_val,
  output logic              flag,
  output logic              ie,
  output logic              match_ev,
  output logic              clr_ev,
  output logic              irq
);
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  logic [BYTE_W-1:0] hold_hi, hold_lo;
  logic              got_hi, got_lo, commit, armed;

  always_comb begin
    commit   = (wr_hi | got_hi) & (wr_lo | got_lo);
    match_ev = tick && !cnt_clr && (next_count(count) == cmp_val);
    clr_ev   = sc_wr && !wdata[tmr_pkg::FLAG_BIT] && armed;
    irq      = flag & ie;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_hi <= '0;
      hold_lo <= '0;
      got_hi  <= 1'b0;
      got_lo  <= 1'b0;
      cmp_val <= '0;
    end else begin
      if (wr_hi) hold_hi <= wdata;
      if (wr_lo) hold_lo <= wdata;
      if (commit) begin
        cmp_val <= {wr_hi ? wdata : hold_hi, wr_lo ? wdata : hold_lo};
        got_hi  <= 1'b0;
        got_lo  <= 1'b0;
      end else begin
        if (wr_hi) got_hi <= 1'b1;
        if (wr_lo) got_lo <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
      ie    <= 1'b0;
    end else begin
      if (match_ev)    flag <= 1'b1;
      else if (clr_ev) flag <= 1'b0;
      if (clr_ev)             armed <= 1'b0;
      else if (sc_rd && flag) armed <= 1'b1;
      if (sc_wr) ie <= wdata[tmr_pkg::IE_BIT];
    end
  end
endmodule

// File: rtl/ocmp_timer.sv
module ocmp_timer #(
  parameter int BYTE_W = 8,
  parameter int PS_W   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [tmr_pkg::ADDR_W-1:0] bus_addr,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [BYTE_W-1:0]         bus_wdata,
  output logic [BYTE_W-1:0]         bus_rdata,
  input  logic                      alt_tick,
  output logic                      irq
);
  import tmr_pkg::*;
  localparam int CNT_W = 2 * BYTE_W;

  logic [PS_W-1:0]   ps_code;
  logic [1:0]        src_sel;
  logic              tick, cnt_clr, rd_hi, rd_lo, wr_vhi, wr_vlo, sc_rd, sc_wr;
  logic [CNT_W-1:0]  count, cmp_val;
  logic [BYTE_W-1:0] hi_byte, lo_byte;
  logic              flag, ie, match_ev, clr_ev;

  always_comb begin
    cnt_clr = bus_wr && (bus_addr == A_CNT_HI || bus_addr == A_CNT_LO);
    rd_hi   = bus_rd && (bus_addr == A_CNT_HI);
    rd_lo   = bus_rd && (bus_addr == A_CNT_LO);
    wr_vhi  = bus_wr && (bus_addr == A_VAL_HI);
    wr_vlo  = bus_wr && (bus_addr == A_VAL_LO);
    sc_rd   = bus_rd && (bus_addr == A_CH_SC);
    sc_wr   = bus_wr && (bus_addr == A_CH_SC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_code <= '0;
      src_sel <= SRC_OFF;
    end else if (bus_wr && bus_addr == A_CTRL) begin
      ps_code <= bus_wdata[PS_W-1:0];
      src_sel <= bus_wdata[PS_W+1:PS_W];
    end
  end

  tmr_prescale #(.PS_W(PS_W)) u_ps (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .ps_code(ps_code),
    .alt_tick(alt_tick), .restart(cnt_clr), .tick(tick)
  );

  tmr_counter #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(cnt_clr),
    .rd_hi(rd_hi), .rd_lo(rd_lo), .count(count),
    .hi_byte(hi_byte), .lo_byte(lo_byte)
  );

  tmr_channel #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_ch (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_clr(cnt_clr), .count(count),
    .wr_hi(wr_vhi), .wr_lo(wr_vlo), .sc_rd(sc_rd), .sc_wr(sc_wr),
    .wdata(bus_wdata), .cmp_val(cmp_val), .flag(flag), .ie(ie),
    .match_ev(match_ev), .clr_ev(clr_ev), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:   bus_rdata = BYTE_W'({src_sel, ps_code});
      A_CNT_HI: bus_rdata = hi_byte;
      A_CNT_LO: bus_rdata = lo_byte;
      A_CH_SC: begin
        bus_rdata[FLAG_BIT] = flag;
        bus_rdata[IE_BIT]   = ie;
      end
      A_VAL_HI: bus_rdata = cmp_val[CNT_W-1:BYTE_W];
      A_VAL_LO: bus_rdata = cmp_val[BYTE_W-1:0];
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ocmp_timer_chk.sv
module ocmp_timer_chk #(
  parameter int BYTE_W = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [tmr_pkg::ADDR_W-1:0] bus_addr,
  input logic                       bus_wr,
  input logic [BYTE_W-1:0]          bus_wdata,
  input logic [2*BYTE_W-1:0]        count,
  input logic [2*BYTE_W-1:0]        cmp_val,
  input logic [1:0]                 src_sel,
  input logic                       match_ev,
  input logic                       flag,
  input logic                       irq
);
  import tmr_pkg::*;

  logic cnt_wr, sc_zero_wr, sc_ie_wr, val_wr;
  always_comb begin
    cnt_wr     = bus_wr && (bus_addr == A_CNT_HI || bus_addr == A_CNT_LO);
    sc_zero_wr = bus_wr && (bus_addr == A_CH_SC) && !bus_wdata[FLAG_BIT];
    sc_ie_wr   = bus_wr && (bus_addr == A_CH_SC) && bus_wdata[IE_BIT];
    val_wr     = bus_wr && (bus_addr == A_VAL_HI || bus_addr == A_VAL_LO);
  end

  assert_stopped_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == SRC_OFF && !cnt_wr) |=> $stable(count));

  assert_cnt_write_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count == '0));

  assert_match_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev |=> (flag && count == cmp_val));

  assert_flag_rise_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(match_ev));

  assert_irq_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(match_ev || sc_ie_wr));

  assert_flag_fall_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(sc_zero_wr && !match_ev));

  assert_val_change_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmp_val) |-> $past(val_wr));
endmodule

bind ocmp_timer ocmp_timer_chk #(.BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .count(count), .cmp_val(cmp_val), .src_sel(src_sel),
  .match_ev(match_ev), .flag(flag), .irq(irq)
);

// File: tb/ocmp_timer_tb_top.sv
`timescale 1ns/1ps
module ocmp_timer_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       alt_tick = 1'b0;
  logic       irq;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  ocmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alt_tick(alt_tick), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  // Every task starts and ends on a falling edge and spans whole clocks.
  task automatic bw(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tk(input int n);
    alt_tick = 1'b1;
    repeat (n) @(negedge clk);
    alt_tick = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    #1;
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, e);
    end
  endtask

  // Monitor: pops the expected byte for each read strobe.
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (bus_rd) begin
      if (exp_q.size() != 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (bus_rdata !== e) begin
          failures++;
          $display("FAIL %s addr=%0d actual=%h expected=%h", t, bus_addr, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 190000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    rd(3'd0, 8'h00, "R9 ctrl");
    rd(3'd1, 8'h00, "R9 cnt_hi");
    rd(3'd2, 8'h00, "R9 cnt_lo");
    rd(3'd3, 8'h00, "R9 ch_sc");
    rd(3'd4, 8'h00, "R9 val_hi");
    rd(3'd5, 8'h00, "R9 val_lo");
    chk_irq(1'b0, "R9");

    // R1 source off keeps the counter still
    idle(10);
    rd(3'd2, 8'h00, "R1 stopped");

    // R1 bus clock: 9 idle cycles between start and stop give 10 ticks
    bw(3'd1, 8'h00);
    bw(3'd0, 8'h08);
    idle(9);
    bw(3'd0, 8'h00);
    rd(3'd1, 8'h00, "R1 bus hi");
    rd(3'd2, 8'h0A, "R1 bus lo");

    // R1 alternate source counts only alt_tick cycles
    bw(3'd2, 8'h00);
    bw(3'd0, 8'h10);
    idle(5);
    rd(3'd2, 8'h00, "R1 alt idle");
    tk(3);
    rd(3'd2, 8'h03, "R1 alt ticks");

    // R2 prescale /8: 20 source cycles give 2 ticks
    bw(3'd0, 8'h00);
    bw(3'd1, 8'h00);
    bw(3'd0, 8'h0B);
    idle(19);
    bw(3'd0, 8'h00);
    rd(3'd2, 8'h02, "R2 div8");

    // R2 prescale /128: 300 source cycles give 2 ticks
    bw(3'd1, 8'h00);
    bw(3'd0, 8'h0F);
    idle(299);
    bw(3'd0, 8'h00);
    rd(3'd2, 8'h02, "R2 div128");

    // R8 read snapshot
    bw(3'd0, 8'h10);
    bw(3'd1, 8'h00);
    tk(291);
    rd(3'd1, 8'h01, "R8 hi");
    tk(32);
    rd(3'd2, 8'h23, "R8 lo snapshot");
    rd(3'd2, 8'h43, "R8 lo live");

    // R3 low-byte write clears the whole counter
    bw(3'd2, 8'h55);
    rd(3'd1, 8'h00, "R3 clr hi");
    rd(3'd2, 8'h00, "R3 clr lo");

    // R7 compare value staging, both orders
    bw(3'd4, 8'h12);
    rd(3'd4, 8'h00, "R7 hi pending");
    rd(3'd5, 8'h00, "R7 lo pending");
    bw(3'd5, 8'h34);
    rd(3'd4, 8'h12, "R7 hi commit");
    rd(3'd5, 8'h34, "R7 lo commit");
    bw(3'd5, 8'h05);
    rd(3'd5, 8'h34, "R7 lo first pending");
    bw(3'd4, 8'h00);
    rd(3'd4, 8'h00, "R7 hi second");
    rd(3'd5, 8'h05, "R7 lo second");

    // R4 / R5 match with interrupt enabled
    bw(3'd3, 8'h40);
    bw(3'd1, 8'h00);
    tk(4);
    rd(3'd3, 8'h40, "R4 no flag before match");
    chk_irq(1'b0, "R5 before match");
    tk(1);
    chk_irq(1'b1, "R5 after match");

    // R6 clear handshake
    bw(3'd3, 8'h40);
    rd(3'd3, 8'hC0, "R6 zero write without read");
    bw(3'd3, 8'hC0);
    rd(3'd3, 8'hC0, "R6 one write");
    bw(3'd3, 8'h40);
    rd(3'd3, 8'h40, "R6 cleared");
    chk_irq(1'b0, "R5 after clear");

    // R5 gating with enable off
    bw(3'd3, 8'h00);
    bw(3'd1, 8'h00);
    tk(5);
    rd(3'd3, 8'h80, "R4 flag ie off");
    chk_irq(1'b0, "R5 ie off");

    // R6 match beats a clear in the same cycle
    bw(3'd1, 8'h00);
    tk(4);
    bus_addr = 3'd3; bus_wdata = 8'h00; bus_wr = 1'b1; alt_tick = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; alt_tick = 1'b0;
    rd(3'd3, 8'h80, "R6 set wins");
    rd(3'd2, 8'h05, "R4 count at match");

    // R3 wrap: 65537 ticks from zero
    bw(3'd1, 8'h00);
    bw(3'd0, 8'h08);
    idle(65536);
    bw(3'd0, 8'h00);
    rd(3'd1, 8'h00, "R3 wrap hi");
    rd(3'd2, 8'h01, "R3 wrap lo");

    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule